// File: doc/BRIEF.md
# Pipelined FP32 Reduction Tree

This block adds up a vector of N single-precision floating-point words in one pass through a binary tree of two-input adders. Level 0 of the tree is the raw input vector. Each later level has half as many adders as the one before it, and the lone node of the last level is the result. The pairing is fixed, so a software model that sums the same way gives the same bits.

Every adder level can take fresh operands on each clock. A whole new vector may therefore be presented every cycle, and one sum comes out per vector after a fixed latency. The adder is a compact two-stage FP32 unit that rounds to nearest-even and flushes subnormals to zero. Parameters decide where pipeline registers go: after any chosen tree level, and between the two internal stages of every adder. Register placement changes the latency but never the sum. With the defaults, N = 1024 and the tree has 10 levels, 1023 adders and a 15-cycle latency.

Top module: `fpsum_reduce`

## Requirements
- R1: Input word i is `in_data[32*i+31:32*i]`, and all words use FP32 layout: sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0. Node i of level k (k >= 1) is the FP sum of nodes 2i and 2i+1 of level k-1, and `out_sum` is the single node of the top level, bit-exact to that order.
- R2: A new input vector is accepted on every cycle in which `in_valid` is high, including back-to-back cycles, and each accepted vector yields exactly one result.
- R3: `out_valid` is `in_valid` delayed by exactly LAT cycles, independent of the data. LAT = (MID_REG ? log2(N) : 0) + (number of set bits among LEVEL_REGS[log2(N)-2:0]) + 1. The top level is always registered.
- R4: Each add rounds to nearest, with ties going to an even fraction LSB.
- R5: A subnormal input is treated as a zero of the same sign, and a result below the smallest normal exponent becomes a zero carrying the result's sign. An exact cancellation gives +0, and -0 plus -0 gives -0.
- R6: An add with a NaN operand, or with infinities of opposite sign, returns 0x7FC00000.
- R7: A result exceeding the largest finite magnitude becomes infinity of its sign (0x7F800000 or 0xFF800000), and infinity plus a finite value returns that infinity.
- R8: For the same inputs, the sum does not depend on LEVEL_REGS or MID_REG.
- R9: A synchronous active-high `rst` drops every vector in flight. No `out_valid` appears for them, and `out_valid` is low during reset and on the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Input vector strobe |
| in_data | input | N*32 | N FP32 words, word i at bits 32*i+31:32*i |
| out_valid | output | 1 | Result strobe |
| out_sum | output | 32 | FP32 sum of the vector |

## Verification
The bench places a deep pipeline and a fully combinational tree side by side. If register placement leaked into the arithmetic, or a valid strobe were misaligned with its data, the two would disagree or miss their expected cycle.

Directed vectors cover the corner cases:
- Rounding ties: an adder that truncates, or rounds ties away from zero, drifts one ULP off.
- Catastrophic cancellation: this exposes a faulty leading-zero shift or a wrongly signed zero.
- Subnormal flush and underflow: a design without them leaks denormals.
- Overflow to infinity: a design that saturates returns the largest finite value instead.
- NaN with a payload and infinities of opposite sign: a design that propagates the payload fails these.

A reset in the middle of a burst shows whether stale vectors still raise `out_valid`.

// File: rtl/fpsum_pkg.sv
package fpsum_pkg;
  typedef logic [31:0] fp32_t;

  localparam fp32_t CANON_NAN = 32'h7FC0_0000;

  // Result of the alignment stage, handed to the rounding stage
  typedef struct packed {
    logic        spec;      // result fully decided by special-case logic
    fp32_t       spec_val;
    logic        sgn;       // sign of the larger-magnitude operand
    logic        sub;       // effective subtraction
    logic [7:0]  exp;       // exponent of the larger operand
    logic [26:0] mbig;      // 1.f with three guard positions
    logic [26:0] msml;      // aligned smaller operand, sticky in bit 0
  } align_t;

  function automatic int unsigned tree_latency(int unsigned levels,
                                               logic [31:0] mask, bit mid);
    int unsigned c;
    c = 1 + (mid ? levels : 0);
    for (int unsigned k = 0; k + 1 < levels; k++)
      if (mask[k]) c++;
    return c;
  endfunction
endpackage

// File: rtl/fpsum_align.sv
module fpsum_align
  import fpsum_pkg::*;
(
  input  fp32_t  a,
  input  fp32_t  b,
  output align_t y
);
  logic        a_z, b_z, a_inf, b_inf, a_nan, b_nan, swap;
  fp32_t       big, sml;
  logic [7:0]  d;
  logic [26:0] sml_ext, shifted, lostmask;

  always_comb begin
    a_z   = (a[30:23] == 8'd0);
    b_z   = (b[30:23] == 8'd0);
    a_inf = (a[30:23] == 8'hFF) && (a[22:0] == 23'd0);
    b_inf = (b[30:23] == 8'hFF) && (b[22:0] == 23'd0);
    a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
    b_nan = (b[30:23] == 8'hFF) && (b[22:0] != 23'd0);

    swap    = (b[30:0] > a[30:0]);
    big     = swap ? b : a;
    sml     = swap ? a : b;
    d       = big[30:23] - sml[30:23];
    sml_ext = {1'b1, sml[22:0], 3'b000};

    y.mbig = {1'b1, big[22:0], 3'b000};
    y.sgn  = big[31];
    y.sub  = a[31] ^ b[31];
    y.exp  = big[30:23];

    if (d >= 8'd27) begin
      shifted  = '0;
      lostmask = '0;
      y.msml   = 27'd1;
    end else begin
      shifted  = sml_ext >> d;
      lostmask = (27'd1 << d) - 27'd1;
      y.msml   = {shifted[26:1], shifted[0] | (|(sml_ext & lostmask))};
    end

    y.spec     = 1'b1;
    y.spec_val = CANON_NAN;
    if (a_nan || b_nan || (a_inf && b_inf && (a[31] != b[31])))
      y.spec_val = CANON_NAN;
    else if (a_inf)
      y.spec_val = a;
    else if (b_inf)
      y.spec_val = b;
    else if (a_z && b_z)
      y.spec_val = {a[31] & b[31], 31'd0};
    else if (a_z)
      y.spec_val = b;
    else if (b_z)
      y.spec_val = a;
    else
      y.spec = 1'b0;
  end
endmodule

// File: rtl/fpsum_round.sv
module fpsum_round
  import fpsum_pkg::*;
(
  input  align_t x,
  output fp32_t  y
);
  logic [27:0]       s;
  logic [26:0]       n;
  logic [4:0]        lz;
  logic signed [9:0] e_pre, e_post;
  logic              rnd;
  logic [24:0]       m;

  always_comb begin
    s = x.sub ? ({1'b0, x.mbig} - {1'b0, x.msml})
              : ({1'b0, x.mbig} + {1'b0, x.msml});
    lz = '0;
    for (int i = 0; i < 27; i++)
      if (s[i]) lz = 5'(26 - i);

    if (s[27]) begin
      n     = {s[27:2], s[1] | s[0]};
      e_pre = $signed({2'b00, x.exp}) + 10'sd1;
    end else begin
      n     = s[26:0] << lz;
      e_pre = $signed({2'b00, x.exp}) - $signed({5'd0, lz});
    end

    rnd    = n[2] & (n[3] | n[1] | n[0]);
    m      = {1'b0, n[26:3]} + 25'(rnd);
    e_post = e_pre + (m[24] ? 10'sd1 : 10'sd0);

    if (x.spec)
      y = x.spec_val;
    else if (s == 28'd0)
      y = 32'd0;
    else if (e_pre <= 10'sd0)
      y = {x.sgn, 31'd0};
    else if (e_post >= 10'sd255)
      y = {x.sgn, 8'hFF, 23'd0};
    else
      y = {x.sgn, e_post[7:0], m[22:0]};
  end
endmodule

// File: rtl/fpsum_adder.sv
module fpsum_adder
  import fpsum_pkg::*;
#(
  parameter bit MID_REG = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic  clk,
  input  fp32_t a,
  input  fp32_t b,
  output fp32_t y
);
  align_t al, al_q;
  fp32_t  sum;

  fpsum_align u_align (.a(a), .b(b), .y(al));

  if (MID_REG) begin : g_mid
    always_ff @(posedge clk) al_q <= al;
  end else begin : g_nomid
    assign al_q = al;
  end

  fpsum_round u_round (.x(al_q), .y(sum));

  if (OUT_REG) begin : g_out
    always_ff @(posedge clk) y <= sum;
  end else begin : g_noout
    assign y = sum;
  end
endmodule

// File: rtl/fpsum_tree.sv
module fpsum_tree
  import fpsum_pkg::*;
#(
  parameter int          N          = 1024,
  parameter logic [31:0] LEVEL_REGS = 32'h0000_00AA,
  parameter bit          MID_REG    = 1'b1
) (
  input  logic          clk,
  input  logic [N*32-1:0] in_data,
  output fp32_t         sum
);
  localparam int LEVELS = $clog2(N);
  localparam int NODES  = 2 * N - 1;

  fp32_t node [NODES];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign node[i] = in_data[32*i +: 32];
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int SRC  = 2 * N - ((2 * N) >> (l - 1));
    localparam int DST  = 2 * N - ((2 * N) >> l);
    localparam bit OREG = (l == LEVELS) ? 1'b1 : LEVEL_REGS[l-1];
    for (genvar i = 0; i < (N >> l); i++) begin : g_add
      fpsum_adder #(.MID_REG(MID_REG), .OUT_REG(OREG)) u_add (
        .clk (clk),
        .a   (node[SRC + 2*i]),
        .b   (node[SRC + 2*i + 1]),
        .y   (node[DST + i])
      );
    end
  end

  assign sum = node[NODES-1];
endmodule

// File: rtl/fpsum_reduce.sv
module fpsum_reduce
  import fpsum_pkg::*;
#(
  parameter int          N          = 1024,
  parameter logic [31:0] LEVEL_REGS = 32'h0000_00AA,
  parameter bit          MID_REG    = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [N*32-1:0] in_data,
  output logic            out_valid,
  output logic [31:0]     out_sum
);
  localparam int LEVELS = $clog2(N);
  localparam int LAT    = int'(tree_latency(LEVELS, LEVEL_REGS, MID_REG));

  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= (vpipe << 1) | LAT'(in_valid);
  end

  assign out_valid = vpipe[LAT-1];

  fpsum_tree #(.N(N), .LEVEL_REGS(LEVEL_REGS), .MID_REG(MID_REG)) u_tree (
    .clk     (clk),
    .in_data (in_data),
    .sum     (out_sum)
  );
endmodule

// File: rtl/fpsum_reduce_chk.sv
module fpsum_reduce_chk #(
  parameter int LAT = 1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] out_sum
);
  logic [15:0] pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + 16'(in_valid) - 16'(out_valid);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid); // R9
  AST_NO_ORPHAN_VALID: assert property (@(posedge clk) disable iff (rst) out_valid |-> (pend != 16'd0)); // R2
  AST_INFLIGHT_LIMIT: assert property (@(posedge clk) disable iff (rst) pend <= 16'(LAT)); // R3
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst) (out_valid && out_sum[30:23] == 8'hFF && out_sum[22:0] != 23'd0) |-> (out_sum == 32'h7FC0_0000)); // R6
  AST_NO_DENORM: assert property (@(posedge clk) disable iff (rst) out_valid |-> (out_sum[30:23] != 8'd0 || out_sum[22:0] == 23'd0)); // R5
endmodule

bind fpsum_reduce fpsum_reduce_chk #(.LAT(LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sum   (out_sum)
);

// File: tb/tb_fpsum_reduce.sv
module tb_fpsum_reduce;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 8;
  localparam int LAT_A      = 5;   // 3 mid stages + level-1 register + top register
  localparam int LAT_B      = 1;   // only the forced top register

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [NB*32-1:0]  in_data = '0;
  logic              va, vb;
  logic [31:0]       sa, sb;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [31:0] qa_val[$], qb_val[$];
  int          qa_t[$],   qb_t[$];
  string       qa_tag[$], qb_tag[$];

  fpsum_reduce #(.N(NB), .LEVEL_REGS(32'h1), .MID_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(va), .out_sum(sa));

  fpsum_reduce #(.N(NB), .LEVEL_REGS(32'h0), .MID_REG(1'b0)) dut_flat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(vb), .out_sum(sb));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // ---------------- reference model ----------------
  function automatic real to_real(input logic [31:0] f);
    logic [10:0] e11;
    e11 = {3'b000, f[30:23]} + 11'd896;
    return $bitstoreal({f[31], e11, f[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] fadd_ref(input logic [31:0] a_in, input logic [31:0] b_in);
    logic [31:0] a, b;
    logic        an, bn, ai, bi, g, st, up;
    int          ea, eb, se;
    real         s;
    logic [63:0] bits;
    logic [23:0] mant;
    logic [24:0] m25;
    a = a_in; b = b_in;
    if (a[30:23] == 8'd0) a = {a[31], 31'd0};
    if (b[30:23] == 8'd0) b = {b[31], 31'd0};
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    if (an || bn) return 32'h7FC0_0000;
    if (ai && bi) return (a[31] == b[31]) ? a : 32'h7FC0_0000;
    if (ai) return a;
    if (bi) return b;
    if (a[30:0] == 0 && b[30:0] == 0) return {a[31] & b[31], 31'd0};
    if (a[30:0] == 0) return b;
    if (b[30:0] == 0) return a;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if (ea - eb >= 29) return a;
    if (eb - ea >= 29) return b;
    s = to_real(a) + to_real(b);      // exact in double for this range
    if (s == 0.0) return 32'd0;
    bits = $realtobits(s);
    se   = int'(bits[62:52]) - 896;
    if (se <= 0) return {bits[63], 31'd0};
    mant = {1'b1, bits[51:29]};
    g    = bits[28];
    st   = |bits[27:0];
    up   = g & (st | mant[0]);
    m25  = {1'b0, mant} + 25'(up);
    if (m25[24]) se++;
    if (se >= 255) return {bits[63], 8'hFF, 23'd0};
    return {bits[63], se[7:0], m25[22:0]};
  endfunction

  function automatic logic [31:0] tree_ref(input logic [NB*32-1:0] v);
    logic [31:0] w [NB];
    for (int i = 0; i < NB; i++) w[i] = v[32*i +: 32];
    for (int cnt = NB/2; cnt >= 1; cnt = cnt / 2)
      for (int i = 0; i < cnt; i++) w[i] = fadd_ref(w[2*i], w[2*i+1]);
    return w[0];
  endfunction

  // ---------------- driver ----------------
  task automatic send(input logic [NB*32-1:0] v, input string tag);
    logic [31:0] e;
    @(negedge clk);
    e = tree_ref(v);
    in_valid = 1'b1;
    in_data  = v;
    qa_val.push_back(e); qa_t.push_back(cyc); qa_tag.push_back(tag);
    qb_val.push_back(e); qb_t.push_back(cyc); qb_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [NB*32-1:0] two(input logic [31:0] w0, input logic [31:0] w1);
    logic [NB*32-1:0] v;
    v = '0;
    v[31:0]  = w0;
    v[63:32] = w1;
    return v;
  endfunction

  function automatic logic [31:0] rnd_fp(input bit wide);
    logic [31:0] r;
    logic [7:0]  ex;
    r  = $urandom;
    ex = wide ? 8'($urandom_range(1, 254)) : 8'($urandom_range(110, 140));
    return {r[31], ex, r[22:0]};
  endfunction

  // ---------------- monitor / scoreboard ----------------
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (!rst) begin
        if (va) begin
          if (qa_val.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 deep pipe unexpected out_valid actual=1 expected=0");
          end else begin
            check({qa_tag.pop_front(), " deep"}, sa, qa_val.pop_front());
            check("R3 deep latency", 32'(cyc - qa_t.pop_front()), 32'(LAT_A));
          end
        end
        if (vb) begin
          if (qb_val.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 flat unexpected out_valid actual=1 expected=0");
          end else begin
            check({qb_tag.pop_front(), " R8 flat"}, sb, qb_val.pop_front());
            check("R3 flat latency", 32'(cyc - qb_t.pop_front()), 32'(LAT_B));
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset deep valid", 32'(va), 32'd0);
    check("R9 reset flat valid", 32'(vb), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 post-reset valid", 32'(va), 32'd0);

    // R1 distinct values 1..8
    send({32'h4100_0000, 32'h40E0_0000, 32'h40C0_0000, 32'h40A0_0000,
          32'h4080_0000, 32'h4040_0000, 32'h4000_0000, 32'h3F80_0000}, "R1 ordered");
    // R4 ties
    send(two(32'h3F80_0000, 32'h3380_0000), "R4 tie even");
    send(two(32'h3F80_0001, 32'h3380_0000), "R4 tie up");
    // R5 cancellation, zeros, flush
    send(two(32'h3F80_0001, 32'hBF80_0000), "R5 partial cancel");
    send({{6{32'h8000_0000}}, 32'hC049_0FDB, 32'h4049_0FDB}, "R5 full cancel");
    send({NB{32'h8000_0000}}, "R5 negative zeros");
    send({NB{32'h8000_0001}}, "R5 subnormal inputs");
    send(two(32'h00C0_0000, 32'h8080_0000), "R5 underflow flush");
    // R7 overflow and infinity
    send({NB{32'h7F7F_FFFF}}, "R7 overflow pos");
    send({NB{32'hFF7F_FFFF}}, "R7 overflow neg");
    send(two(32'h7F80_0000, 32'h3F80_0000), "R7 inf plus finite");
    // R6 NaN
    send({{4{32'h3F80_0000}}, 32'h7FC1_2345, {3{32'h4000_0000}}}, "R6 payload NaN");
    send(two(32'h7F80_0000, 32'hFF80_0000), "R6 inf minus inf");
    // R1/R2/R4 random back-to-back, mixed signs
    for (int k = 0; k < 40; k++) begin
      logic [NB*32-1:0] v;
      for (int i = 0; i < NB; i++) v[32*i +: 32] = rnd_fp(1'b0);
      send(v, "R1 R2 R4 random narrow");
    end
    for (int k = 0; k < 20; k++) begin
      logic [NB*32-1:0] v;
      for (int i = 0; i < NB; i++) v[32*i +: 32] = rnd_fp(1'b1);
      send(v, "R1 R7 random wide");
    end
    idle(LAT_A + 4);
    check("R2 deep results drained", 32'(qa_val.size()), 32'd0);
    check("R2 flat results drained", 32'(qb_val.size()), 32'd0);

    // R9 reset while vectors are in flight
    send({NB{32'h3F80_0000}}, "R9 pre-reset");
    send({NB{32'h4000_0000}}, "R9 pre-reset");
    @(negedge clk);
    in_valid = 1'b0;
    rst      = 1'b1;
    qa_val.delete(); qa_t.delete(); qa_tag.delete();
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < LAT_A + 2; k++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R9 dropped vectors stay silent", 32'(va), 32'd0);
    end
    check("R9 flat queue empty", 32'(qb_val.size()), 32'd0);

    // pipeline usable again after reset
    send({NB{32'h3F80_0000}}, "R9 after reset");
    idle(LAT_A + 3);
    check("R9 deep result after reset", 32'(qa_val.size()), 32'd0);
    finish_run();
  end
endmodule